// File: doc/BRIEF.md
# Link Ping Request Responder

This block runs the ping exchange on a point-to-point serial link, in either link role. On the replying (slave) side it asks the framer to send a ping reply frame carrying an 8-bit payload. Software can queue such a reply by setting a request flag. The block can also queue one by itself when a ping control frame arrives, if automatic reply is enabled. On the initiating (master) side the same 8-bit field holds the payload the block expects back. Each received ping reply is compared against it, and the outcome is kept in two sticky flags.

Software uses two register addresses: one for configuration and one for status. The receiver presents each decoded frame as a one-cycle strobe with a type code and a payload. The framer takes a reply through a request/grant handshake and reads the payload from a register that is loaded at grant. Serialization and the rest of the frame format are handled elsewhere.

Top module: `pingResponder`

## Requirements
- R1: After reset, both readable registers read zero, `txReq` is low, `txPayload` is zero and both result flags are low.
- R2: The configuration register sits at `regAddr`=0. The payload field is bits [7:0], the auto-reply enable is bit 15 and the reply request is bit 16 (bit 0 is the LSB). All other bits read as zero.
- R3: Writing the configuration register with bit 16 set queues one reply: from the next cycle `txReq` is high and bit 16 reads 1. Writing bit 16 as 0 does not cancel a pending request.
- R4: `txReq` stays high until a cycle in which `txGrant` is high. In that grant cycle all pending requests are consumed, so `txReq` is low in the next cycle and bit 16 reads 0.
- R5: In the grant cycle `txPayload` loads the payload field. It then holds that value through any later register writes until the next grant.
- R6: In slave role (`roleMaster`=0) with auto-reply enabled, a received frame with `rxType`=1 (ping control) raises `txReq` from the next cycle. Bit 16 still reads 0.
- R7: With auto-reply disabled, a ping control frame causes no reply.
- R8: A software request and an automatic trigger pending together produce exactly one reply frame. Its grant clears both.
- R9: In master role (`roleMaster`=1), each received frame with `rxType`=2 (ping reply) is compared with the payload field. Equal sets the match flag and different sets the mismatch flag; both flags are sticky. Ping control frames never trigger a reply in master role.
- R10: The status register sits at `regAddr`=1, with bit 0 as match and bit 1 as mismatch. Writing 1 to a bit clears it and writing 0 has no effect. A reply result arriving in the same cycle as a clear leaves the flag set.
- R11: A request or ping control frame that arrives in the grant cycle is not lost. `txReq` stays high for a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| roleMaster | input | 1 | 1 = master role, 0 = slave role |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 configuration, 1 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| rxValid | input | 1 | Received frame strobe, one cycle per frame |
| rxType | input | 2 | Received frame type: 1 ping control, 2 ping reply |
| rxPayload | input | 8 | Received frame payload |
| txReq | output | 1 | Reply frame request to the framer |
| txGrant | input | 1 | Framer accepts the request |
| txPayload | output | 8 | Payload of the granted reply frame |
| matchFlag | output | 1 | Sticky: a reply matched the expected payload |
| mismatchFlag | output | 1 | Sticky: a reply differed from the expected payload |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the framer's grant and a fresh trigger, either a request write or a ping control frame. The second pair is a status clear and a reply result for the same flag. The bench raises `txGrant` in the same cycle that it strobes a ping control frame, and the reply must stay requested. It also issues a clear of the match flag in the same cycle as a matching reply, and the flag must survive. A scoreboard counts the frames the framer takes, so a lost trigger or a duplicated frame shows up as a missing or extra payload.

// File: rtl/pingPkg.sv
package pingPkg;

  localparam int REG_W    = 32;
  localparam int REQ_POS  = 16;
  localparam int AUTO_POS = 15;

  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic statWr;
    logic replyRx;
    logic grantTake;
  } pingStrobe_t;

endpackage

// File: rtl/pingCtrl.sv
module pingCtrl
  import pingPkg::*;
#(
  parameter int TYPE_W = 2,
  parameter logic [TYPE_W-1:0] CTRL_CODE  = 1,
  parameter logic [TYPE_W-1:0] REPLY_CODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              roleMaster,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic              reqBitIn,
  input  logic              autoEn,
  input  logic              rxValid,
  input  logic [TYPE_W-1:0] rxType,
  input  logic              txGrant,
  output pingStrobe_t       strb,
  output logic              txReq,
  output logic              reqPending
);

  logic swReq;
  logic autoReq;
  logic swSet;
  logic autoHit;
  logic grantTake;

  assign swSet     = regWrEn && (regAddr == ADDR_CFG) && reqBitIn;
  assign autoHit   = rxValid && (rxType == CTRL_CODE) && !roleMaster && autoEn;
  assign txReq     = swReq || autoReq;
  assign grantTake = txReq && txGrant;

  always_comb begin
    strb           = '0;
    strb.cfgWr     = regWrEn && (regAddr == ADDR_CFG);
    strb.statWr    = regWrEn && (regAddr == ADDR_STAT);
    strb.replyRx   = rxValid && (rxType == REPLY_CODE) && roleMaster;
    strb.grantTake = grantTake;
  end

  // A new trigger in the grant cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swReq   <= 1'b0;
      autoReq <= 1'b0;
    end else begin
      if (swSet)          swReq <= 1'b1;
      else if (grantTake) swReq <= 1'b0;
      if (autoHit)        autoReq <= 1'b1;
      else if (grantTake) autoReq <= 1'b0;
    end
  end

  assign reqPending = swReq;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txGrant |=> txReq);                                  // R4
  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txGrant && !swSet && !autoHit |=> !txReq);            // R8
  AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !txReq && rxValid && (rxType == CTRL_CODE) && !autoEn && !swSet |=> !txReq); // R7
  AST_MASTER_NO_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    !txReq && roleMaster && !swSet |=> !txReq);                    // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    swSet |=> reqPending && txReq);                                // R11

endmodule

// File: rtl/pingDatapath.sv
module pingDatapath
  import pingPkg::*;
#(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pingStrobe_t          strb,
  input  logic                 regAddr,
  input  logic                 cfgAuto,
  input  logic [PAYLOAD_W-1:0] cfgPayload,
  input  logic                 clrMatch,
  input  logic                 clrMiss,
  input  logic [PAYLOAD_W-1:0] rxPayload,
  input  logic                 reqPending,
  output logic                 autoEn,
  output logic [PAYLOAD_W-1:0] txPayload,
  output logic                 matchFlag,
  output logic                 mismatchFlag,
  output logic [REG_W-1:0]     rdData
);

  logic [PAYLOAD_W-1:0] payloadField;
  logic [PAYLOAD_W-1:0] frameReg;
  logic                 autoReg;
  logic                 matchReg;
  logic                 missReg;
  logic                 payloadEq;

  assign payloadEq = (rxPayload == payloadField);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payloadField <= '0;
      autoReg      <= 1'b0;
    end else if (strb.cfgWr) begin
      payloadField <= cfgPayload;
      autoReg      <= cfgAuto;
    end
  end

  // Frame payload is frozen at grant
  always_ff @(posedge clk) begin
    if (!rstN)               frameReg <= '0;
    else if (strb.grantTake) frameReg <= payloadField;
  end

  // Sticky results; a new result beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchReg <= 1'b0;
      missReg  <= 1'b0;
    end else begin
      matchReg <= (strb.replyRx && payloadEq) ||
                  (matchReg && !(strb.statWr && clrMatch));
      missReg  <= (strb.replyRx && !payloadEq) ||
                  (missReg && !(strb.statWr && clrMiss));
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_CFG) begin
      rdData[REQ_POS]         = reqPending;
      rdData[AUTO_POS]        = autoReg;
      rdData[PAYLOAD_W-1:0]   = payloadField;
    end else begin
      rdData[0] = matchReg;
      rdData[1] = missReg;
    end
  end

  assign autoEn       = autoReg;
  assign txPayload    = frameReg;
  assign matchFlag    = matchReg;
  assign mismatchFlag = missReg;

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.grantTake |=> $stable(txPayload));                        // R5
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantTake |=> txPayload == $past(payloadField));           // R5
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag && !(strb.statWr && clrMatch) |=> matchFlag);         // R10
  AST_MISMATCH_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.replyRx && (rxPayload != payloadField) |=> mismatchFlag);  // R9

endmodule

// File: rtl/pingResponder.sv
module pingResponder
  import pingPkg::*;
#(
  parameter int TYPE_W    = 2,
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 roleMaster,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 rxValid,
  input  logic [TYPE_W-1:0]    rxType,
  input  logic [PAYLOAD_W-1:0] rxPayload,
  output logic                 txReq,
  input  logic                 txGrant,
  output logic [PAYLOAD_W-1:0] txPayload,
  output logic                 matchFlag,
  output logic                 mismatchFlag
);

  pingStrobe_t strb;
  logic        autoEn;
  logic        reqPending;
  logic        unusedWrBits;

  assign unusedWrBits = ^{regWrData[REG_W-1:REQ_POS+1], regWrData[AUTO_POS-1:PAYLOAD_W]};

  pingCtrl #(
    .TYPE_W     (TYPE_W),
    .CTRL_CODE  (TYPE_W'(1)),
    .REPLY_CODE (TYPE_W'(2))
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .roleMaster (roleMaster),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .reqBitIn   (regWrData[REQ_POS]),
    .autoEn     (autoEn),
    .rxValid    (rxValid),
    .rxType     (rxType),
    .txGrant    (txGrant),
    .strb       (strb),
    .txReq      (txReq),
    .reqPending (reqPending)
  );

  pingDatapath #(
    .PAYLOAD_W (PAYLOAD_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regAddr      (regAddr),
    .cfgAuto      (regWrData[AUTO_POS]),
    .cfgPayload   (regWrData[PAYLOAD_W-1:0]),
    .clrMatch     (regWrData[0]),
    .clrMiss      (regWrData[1]),
    .rxPayload    (rxPayload),
    .reqPending   (reqPending),
    .autoEn       (autoEn),
    .txPayload    (txPayload),
    .matchFlag    (matchFlag),
    .mismatchFlag (mismatchFlag),
    .rdData       (regRdData)
  );

endmodule

// File: tb/pingResponder_test.sv
`timescale 1ns/1ps
module pingResponder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        roleMaster = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rxValid = 1'b0;
  logic [1:0]  rxType = '0;
  logic [7:0]  rxPayload = '0;
  logic        txReq;
  logic        txGrant = 1'b0;
  logic [7:0]  txPayload;
  logic        matchFlag;
  logic        mismatchFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] expQ[$];
  logic grantPrev = 1'b0;

  always #4 clk = ~clk;

  pingResponder uut (
    .clk(clk), .rstN(rstN), .roleMaster(roleMaster),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxValid(rxValid), .rxType(rxType), .rxPayload(rxPayload),
    .txReq(txReq), .txGrant(txGrant), .txPayload(txPayload),
    .matchFlag(matchFlag), .mismatchFlag(mismatchFlag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: a frame taken by the framer is compared one cycle later
  always @(posedge clk) grantPrev <= rstN && txGrant && txReq;

  always @(negedge clk) begin
    if (grantPrev) begin
      if (expQ.size() == 0) check(1'b0, "R8 extra frame", {24'h0, txPayload}, 32'h0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(txPayload == e, "R5 frame payload", {24'h0, txPayload}, {24'h0, e});
      end
    end
  end

  task automatic writeReg(input logic a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic rxFrame(input logic [1:0] t, input logic [7:0] p);
    rxValid = 1'b1; rxType = t; rxPayload = p;
    @(negedge clk);
    rxValid = 1'b0; rxType = '0; rxPayload = '0;
  endtask

  // Driver: expects one frame with payload p, then grants it
  task automatic grantOne(input logic [7:0] p);
    expQ.push_back(p);
    txGrant = 1'b1;
    @(negedge clk);
    txGrant = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(1'b0, rd); check(rd == 32'h0, "R1 cfg reset", rd, 32'h0);
    readReg(1'b1, rd); check(rd == 32'h0, "R1 stat reset", rd, 32'h0);
    check(!txReq && txPayload == 8'h0 && !matchFlag && !mismatchFlag, "R1 outputs",
          {txReq, matchFlag, mismatchFlag, txPayload}, 32'h0);

    // R2 layout, reserved bits read zero
    writeReg(1'b0, 32'hFFFE_FFFF);
    readReg(1'b0, rd); check(rd == 32'h0000_80FF, "R2 layout", rd, 32'h0000_80FF);
    check(!txReq, "R2 no request", txReq, 0);

    // R3 software request; writing 0 does not cancel
    writeReg(1'b0, 32'h0001_005A);
    check(txReq, "R3 txReq", txReq, 1);
    readReg(1'b0, rd); check(rd == 32'h0001_005A, "R3 pending read", rd, 32'h0001_005A);
    writeReg(1'b0, 32'h0000_005A);
    readReg(1'b0, rd); check(rd[16] && txReq, "R3 no cancel", rd, 32'h0001_005A);
    // R4 hold without grant
    idle(3);
    check(txReq, "R4 hold", txReq, 1);
    grantOne(8'h5A);
    readReg(1'b0, rd);
    check(!txReq && !rd[16], "R4 cleared", {txReq, rd[16]}, 0);

    // R5 payload frozen after grant
    writeReg(1'b0, 32'h0001_0033);
    grantOne(8'h33);
    writeReg(1'b0, 32'h0000_0099);
    idle(2);
    check(txPayload == 8'h33, "R5 frozen", txPayload, 8'h33);

    // R6 automatic reply in slave role
    writeReg(1'b0, 32'h0000_80C3);
    rxFrame(2'd1, 8'h00);
    readReg(1'b0, rd);
    check(txReq, "R6 auto txReq", txReq, 1);
    check(rd == 32'h0000_80C3, "R6 request bit stays 0", rd, 32'h0000_80C3);
    grantOne(8'hC3);
    check(!txReq, "R6 done", txReq, 0);

    // R7 auto disabled
    writeReg(1'b0, 32'h0000_0011);
    rxFrame(2'd1, 8'h00);
    check(!txReq, "R7 no reply", txReq, 0);
    idle(3);
    check(!txReq, "R7 still none", txReq, 0);

    // R8 software and automatic pending together
    writeReg(1'b0, 32'h0001_80A5);
    rxFrame(2'd1, 8'h00);
    grantOne(8'hA5);
    readReg(1'b0, rd);
    check(!txReq && !rd[16], "R8 single frame", {txReq, rd[16]}, 0);
    idle(3);
    check(!txReq, "R8 no second", txReq, 0);

    // R11 ping control frame in the grant cycle
    writeReg(1'b0, 32'h0001_806E);
    expQ.push_back(8'h6E);
    txGrant = 1'b1; rxValid = 1'b1; rxType = 2'd1;
    @(negedge clk);
    txGrant = 1'b0; rxValid = 1'b0; rxType = '0;
    check(txReq, "R11 rearmed by frame", txReq, 1);
    grantOne(8'h6E);
    // R11 request write in the grant cycle
    writeReg(1'b0, 32'h0001_806E);
    expQ.push_back(8'h6E);
    txGrant = 1'b1; regWrEn = 1'b1; regAddr = 1'b0; regWrData = 32'h0001_8077;
    @(negedge clk);
    txGrant = 1'b0; regWrEn = 1'b0; regWrData = '0;
    readReg(1'b0, rd);
    check(txReq && rd[16], "R11 rearmed by write", rd, 32'h0001_8077);
    grantOne(8'h77);
    check(!txReq, "R11 drained", txReq, 0);

    // R9 master role comparison
    roleMaster = 1'b1;
    writeReg(1'b0, 32'h0000_804D);
    rxFrame(2'd1, 8'h00);
    check(!txReq, "R9 no auto in master", txReq, 0);
    rxFrame(2'd2, 8'h4D);
    readReg(1'b1, rd);
    check(matchFlag && !mismatchFlag && rd == 32'h1, "R9 match", rd, 32'h1);
    rxFrame(2'd2, 8'h4C);
    readReg(1'b1, rd);
    check(rd == 32'h3, "R9 mismatch sticky", rd, 32'h3);

    // R10 write-one-to-clear
    writeReg(1'b1, 32'h0);
    readReg(1'b1, rd); check(rd == 32'h3, "R10 zero write", rd, 32'h3);
    writeReg(1'b1, 32'h2);
    readReg(1'b1, rd); check(rd == 32'h1, "R10 clear mismatch", rd, 32'h1);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 32'h1;
    rxValid = 1'b1; rxType = 2'd2; rxPayload = 8'h4D;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; rxValid = 1'b0; rxType = '0; rxPayload = '0;
    readReg(1'b1, rd); check(rd == 32'h1, "R10 set wins", rd, 32'h1);
    writeReg(1'b1, 32'h1);
    readReg(1'b1, rd); check(rd == 32'h0 && !matchFlag, "R10 cleared", rd, 32'h0);

    idle(2);
    check(expQ.size() == 0, "R8 frames outstanding", expQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule